// File: doc/BRIEF.md
# Operator Panel Run and Access Sequencer

This block sits between an operator's switch panel and a small 8-bit bit-serial processor. While the processor is stopped, it turns single-cycle button pulses into writes to the processor's program counter, memory-address and memory-buffer registers and into memory accesses. This is how an operator sets an address, stores bytes into memory, or reads them back one location at a time. Deposit and examine both step the program counter. They leave the touched location in the memory-address register.

When the operator starts the machine, the block raises a run enable. It also produces a one-cycle clock-enable pulse from a programmable divider, which paces the processor's major cycles at a fast or a slow rate. A stop request is held until the processor reports the last major cycle of an instruction, so the machine always halts on an instruction boundary. Single-step mode uses the same mechanism to stop after one instruction. Four lamps show the run state and the current major cycle.

Top module: `panel_sequencer`

## Requirements
- R1: After reset the machine is stopped: `run_en`, `clk_en`, all four lamps and all write strobes (`pc_wr`, `ma_wr`, `mb_wr`, `mem_we`) are low.
- R2: A `btn_load` pulse while stopped drives `pc_wr` for that cycle with `pc_wdata` equal to `sw`.
- R3: A `btn_dep` pulse while stopped writes `sw` to memory at address `cpu_pc` and loads MA with `cpu_pc` and MB with `sw`. In the same cycle it loads PC with `cpu_pc`+1 modulo 256, so 8'hFF steps to 8'h00.
- R4: A `btn_exam` pulse while stopped raises `mem_re` with `mem_addr` equal to `cpu_pc`. In the next cycle, MB is loaded with `mem_rdata`, which is returned one cycle after `mem_re`. In that same cycle MA is loaded with the examined address and PC with that address +1 modulo 256.
- R5: While running, and in the cycle that completes an examine, the access buttons and `btn_run` have no effect: no `pc_wr`, `ma_wr`, `mb_wr` or `mem_we` is produced.
- R6: A `btn_run` pulse while stopped and with `single_mode` low sets `run_en`. A later `btn_halt` pulse clears `run_en` only at an edge where `clk_en` and `cpu_last` are both high. The PC is then left at the next instruction.
- R7: With `single_mode` high, a `btn_run` pulse runs exactly one instruction. `run_en` falls at that instruction's final clock-enable edge.
- R8: `clk_en` is high only while `run_en` is high and never for two cycles in a row. Consecutive pulses are `FAST_DIV` cycles apart when `slow_mode` is low and `SLOW_DIV` cycles apart when it is high. Both divisors must be at least 2.
- R9: `lamp_run` follows `run_en`. While running, exactly one of `lamp_fetch`, `lamp_defer` and `lamp_exec` is lit, selected by `cpu_phase` (2'b00 fetch, 2'b01 defer, 2'b10 exec). All three are dark while stopped.
- R10: When several buttons pulse in the same stopped cycle, only one acts, with priority LOAD over DEP over EXAM over RUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw | input | 8 | Operator data/address switches |
| btn_load | input | 1 | Load-address pulse |
| btn_dep | input | 1 | Deposit pulse |
| btn_exam | input | 1 | Examine pulse |
| btn_run | input | 1 | Start pulse |
| btn_halt | input | 1 | Stop-request pulse |
| single_mode | input | 1 | 1 = one instruction per start |
| slow_mode | input | 1 | 1 = slow divider |
| cpu_pc | input | 8 | Current processor PC |
| cpu_phase | input | 2 | Processor major cycle: 00 fetch, 01 defer, 10 exec |
| cpu_last | input | 1 | Current major cycle is the last of the instruction |
| mem_rdata | input | 8 | Memory read data, one cycle after `mem_re` |
| pc_wr | output | 1 | Load processor PC |
| pc_wdata | output | 8 | Value for PC |
| ma_wr | output | 1 | Load memory-address register |
| ma_wdata | output | 8 | Value for MA |
| mb_wr | output | 1 | Load memory-buffer register |
| mb_wdata | output | 8 | Value for MB |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_addr | output | 8 | Memory address for panel accesses |
| mem_wdata | output | 8 | Memory write data |
| run_en | output | 1 | Processor may execute |
| clk_en | output | 1 | One-cycle major-cycle advance pulse |
| lamp_run | output | 1 | Run lamp |
| lamp_fetch | output | 1 | Fetch lamp |
| lamp_defer | output | 1 | Defer lamp |
| lamp_exec | output | 1 | Execute lamp |

## Verification
The bench steps through memory with deposits at rising addresses and at 8'hFF. This shows whether the PC advance wraps, and whether MA keeps the accessed address instead of the incremented one. Examines read back distinct values, which exposes an MB loaded one cycle early or from the wrong address. The single-step run goes through an indirect instruction, so it has a defer cycle, and this catches a stop taken at the first clock-enable instead of at the instruction end. The continuous runs at both rates have button presses injected mid-run, and they separate a correct divider and boundary-qualified halt from a miscounted period or a stop taken immediately.

// File: rtl/panel_sequencer.sv
module panel_sequencer #(
  parameter int FAST_DIV = 100,
  parameter int SLOW_DIV = 25_000_000,
  localparam int CW = $clog2(SLOW_DIV + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] sw,
  input  logic       btn_load,
  input  logic       btn_dep,
  input  logic       btn_exam,
  input  logic       btn_run,
  input  logic       btn_halt,
  input  logic       single_mode,
  input  logic       slow_mode,
  input  logic [7:0] cpu_pc,
  input  logic [1:0] cpu_phase,
  input  logic       cpu_last,
  input  logic [7:0] mem_rdata,
  output logic       pc_wr,
  output logic [7:0] pc_wdata,
  output logic       ma_wr,
  output logic [7:0] ma_wdata,
  output logic       mb_wr,
  output logic [7:0] mb_wdata,
  output logic       mem_we,
  output logic       mem_re,
  output logic [7:0] mem_addr,
  output logic [7:0] mem_wdata,
  output logic       run_en,
  output logic       clk_en,
  output logic       lamp_run,
  output logic       lamp_fetch,
  output logic       lamp_defer,
  output logic       lamp_exec
);

  localparam logic [CW-1:0] FAST_LIM = CW'(FAST_DIV - 1);
  localparam logic [CW-1:0] SLOW_LIM = CW'(SLOW_DIV - 1);

  logic          run_q, stop_q, exam_q;
  logic [7:0]    exam_addr;
  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;
  logic          idle, do_load, do_dep, do_exam, do_run, stop_now;

  assign idle    = !run_q && !exam_q;
  assign do_load = idle && btn_load;
  assign do_dep  = idle && btn_dep && !btn_load;
  assign do_exam = idle && btn_exam && !btn_load && !btn_dep;
  assign do_run  = idle && btn_run && !btn_load && !btn_dep && !btn_exam;

  assign lim      = slow_mode ? SLOW_LIM : FAST_LIM;
  assign clk_en   = run_q && (cnt >= lim);
  assign stop_now = clk_en && cpu_last && (stop_q || btn_halt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q     <= 1'b0;
      stop_q    <= 1'b0;
      exam_q    <= 1'b0;
      exam_addr <= '0;
      cnt       <= '0;
    end else begin
      exam_q <= do_exam;
      if (do_exam) exam_addr <= cpu_pc;

      if (do_run) begin
        run_q  <= 1'b1;
        stop_q <= single_mode;
      end else if (stop_now) begin
        run_q  <= 1'b0;
        stop_q <= 1'b0;
      end else if (run_q && btn_halt) begin
        stop_q <= 1'b1;
      end

      if (!run_q || clk_en) cnt <= '0;
      else                  cnt <= cnt + 1'b1;
    end
  end

  assign pc_wr    = do_load || do_dep || exam_q;
  assign pc_wdata = do_load ? sw : (exam_q ? exam_addr + 8'd1 : cpu_pc + 8'd1);
  assign ma_wr    = do_dep || exam_q;
  assign ma_wdata = exam_q ? exam_addr : cpu_pc;
  assign mb_wr    = do_dep || exam_q;
  assign mb_wdata = exam_q ? mem_rdata : sw;

  assign mem_we    = do_dep;
  assign mem_re    = do_exam;
  assign mem_addr  = cpu_pc;
  assign mem_wdata = sw;

  assign run_en     = run_q;
  assign lamp_run   = run_q;
  assign lamp_fetch = run_q && cpu_phase == 2'b00;
  assign lamp_defer = run_q && cpu_phase == 2'b01;
  assign lamp_exec  = run_q && cpu_phase == 2'b10;

  // R8
  clk_en_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en |=> !clk_en);

  // R8
  clk_en_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |-> !clk_en);

  // R5
  no_write_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_en |-> !(mem_we || pc_wr || ma_wr || mb_wr));

  // R6
  stop_on_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_en) |-> $past(clk_en && cpu_last));

  // R4
  exam_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mb_wr && !mem_we) |-> $past(mem_re));

  // R9
  lamp_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lamp_fetch, lamp_defer, lamp_exec}));

endmodule

// File: tb/panel_sequencer_bench.sv
module panel_sequencer_bench;
  localparam int FD = 4;
  localparam int SD = 12;

  logic clk = 0, rst_n = 0;
  logic [7:0] sw = 0;
  logic btn_load = 0, btn_dep = 0, btn_exam = 0, btn_run = 0, btn_halt = 0;
  logic single_mode = 0, slow_mode = 0;
  logic [7:0] cpu_pc, mem_rdata;
  logic [1:0] cpu_phase;
  logic cpu_last;
  logic pc_wr, ma_wr, mb_wr, mem_we, mem_re, run_en, clk_en;
  logic [7:0] pc_wdata, ma_wdata, mb_wdata, mem_addr, mem_wdata;
  logic lamp_run, lamp_fetch, lamp_defer, lamp_exec;

  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  panel_sequencer #(.FAST_DIV(FD), .SLOW_DIV(SD)) u_panel_sequencer (
    .clk(clk), .rst_n(rst_n), .sw(sw), .btn_load(btn_load), .btn_dep(btn_dep),
    .btn_exam(btn_exam), .btn_run(btn_run), .btn_halt(btn_halt),
    .single_mode(single_mode), .slow_mode(slow_mode), .cpu_pc(cpu_pc),
    .cpu_phase(cpu_phase), .cpu_last(cpu_last), .mem_rdata(mem_rdata),
    .pc_wr(pc_wr), .pc_wdata(pc_wdata), .ma_wr(ma_wr), .ma_wdata(ma_wdata),
    .mb_wr(mb_wr), .mb_wdata(mb_wdata), .mem_we(mem_we), .mem_re(mem_re),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .run_en(run_en), .clk_en(clk_en),
    .lamp_run(lamp_run), .lamp_fetch(lamp_fetch), .lamp_defer(lamp_defer),
    .lamp_exec(lamp_exec));

  // Simple processor and memory model
  logic [7:0] pc, ma, mb;
  logic [7:0] mem [256];
  int instr_done = 0;
  assign cpu_pc   = pc;
  assign cpu_last = (cpu_phase == 2'b10);

  always @(posedge clk) begin
    if (!rst_n) begin
      pc <= 0; ma <= 0; mb <= 0; cpu_phase <= 2'b00; mem_rdata <= 0;
      for (int i = 0; i < 256; i++) mem[i] <= 8'h00;
    end else begin
      if (pc_wr) pc <= pc_wdata;
      if (ma_wr) ma <= ma_wdata;
      if (mb_wr) mb <= mb_wdata;
      if (mem_we) mem[mem_addr] <= mem_wdata;
      if (mem_re) mem_rdata <= mem[mem_addr];
      if (clk_en) begin
        case (cpu_phase)
          2'b00: cpu_phase <= mem[pc][4] ? 2'b01 : 2'b10;
          2'b01: cpu_phase <= 2'b10;
          default: begin cpu_phase <= 2'b00; pc <= pc + 8'd1; instr_done <= instr_done + 1; end
        endcase
      end
    end
  end

  // Port monitors, sampled on the falling edge
  int cyc = 0, last_tick = -1, last_gap = 0, writes_running = 0, pulse_run2 = 0;
  int lamp_bad = 0, defer_seen = 0;
  logic prev_en = 0;
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (run_en && (pc_wr || ma_wr || mb_wr || mem_we)) writes_running++;
      if (clk_en && prev_en) pulse_run2++;
      if (clk_en && !run_en) pulse_run2++;
      if (run_en && ($countones({lamp_fetch, lamp_defer, lamp_exec}) != 1)) lamp_bad++;
      if (!run_en && (lamp_fetch || lamp_defer || lamp_exec)) lamp_bad++;
      if (lamp_run != run_en) lamp_bad++;
      if (lamp_defer) defer_seen++;
      if (!run_en) last_tick = -1;
      else if (clk_en) begin
        if (last_tick >= 0) last_gap = cyc - last_tick;
        last_tick = cyc;
      end
      prev_en = clk_en;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic press(input int which, input logic [7:0] v);
    @(negedge clk);
    sw = v;
    btn_load = which[0]; btn_dep = which[1]; btn_exam = which[2];
    btn_run = which[3]; btn_halt = which[4];
    @(negedge clk);
    btn_load = 0; btn_dep = 0; btn_exam = 0; btn_run = 0; btn_halt = 0;
  endtask

  task automatic wait_stop(output int ok);
    ok = 0;
    for (int i = 0; i < 3000; i++) begin
      if (!run_en) begin ok = 1; break; end
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    check("R1 run_en", run_en, 0);
    check("R1 clk_en", clk_en, 0);
    check("R1 lamps", {lamp_run, lamp_fetch, lamp_defer, lamp_exec}, 0);
    check("R1 strobes", {pc_wr, ma_wr, mb_wr, mem_we}, 0);
  endtask

  task automatic t_load;
    press(1, 8'h20);
    check("R2 pc", pc, 8'h20);
    press(1, 8'hC7);
    check("R2 pc second", pc, 8'hC7);
  endtask

  task automatic t_dep;
    press(1, 8'h20);
    press(2, 8'h5A); press(2, 8'hA5); press(2, 8'h3C);
    check("R3 mem20", mem[8'h20], 8'h5A);
    check("R3 mem21", mem[8'h21], 8'hA5);
    check("R3 mem22", mem[8'h22], 8'h3C);
    check("R3 ma", ma, 8'h22);
    check("R3 mb", mb, 8'h3C);
    check("R3 pc", pc, 8'h23);
    press(1, 8'hFF);
    press(2, 8'h99);
    check("R3 memFF", mem[8'hFF], 8'h99);
    check("R3 ma wrap", ma, 8'hFF);
    check("R3 pc wrap", pc, 8'h00);
  endtask

  task automatic t_exam;
    press(1, 8'h21);
    press(4, 8'h00);
    @(negedge clk);
    check("R4 mb", mb, 8'hA5);
    check("R4 ma", ma, 8'h21);
    check("R4 pc", pc, 8'h22);
    press(4, 8'h00);
    @(negedge clk);
    check("R4 mb next", mb, 8'h3C);
    check("R4 ma next", ma, 8'h22);
    press(1, 8'hFF);
    press(4, 8'h00);
    @(negedge clk);
    check("R4 mb FF", mb, 8'h99);
    check("R4 pc wrap", pc, 8'h00);
    // R5: a deposit arriving while an examine completes is ignored
    press(1, 8'h21);
    press(4, 8'h00);
    btn_dep = 1; sw = 8'h11;
    @(negedge clk);
    btn_dep = 0;
    check("R5 dep during exam mem", mem[8'h21], 8'hA5);
    check("R5 dep during exam pc", pc, 8'h22);
  endtask

  task automatic t_priority;
    press(1, 8'h30);
    press(3, 8'h50);
    check("R10 load beats dep pc", pc, 8'h50);
    check("R10 load beats dep mem30", mem[8'h30], 0);
    check("R10 load beats dep mem50", mem[8'h50], 0);
    press(2 | 4 | 8, 8'h77);
    check("R10 dep beats exam", mem[8'h50], 8'h77);
    check("R10 dep beats run", run_en, 0);
    check("R10 pc after dep", pc, 8'h51);
  endtask

  task automatic t_single;
    int ok, start;
    press(1, 8'h40);
    press(2, 8'h10);
    press(1, 8'h40);
    single_mode = 1; slow_mode = 0;
    start = instr_done; defer_seen = 0;
    press(8, 8'h00);
    check("R7 running", run_en, 1);
    wait_stop(ok);
    check("R7 stopped", ok, 1);
    check("R7 one instr", instr_done - start, 1);
    check("R7 pc next", pc, 8'h41);
    check("R9 defer lamp", defer_seen > 0, 1);
    check("R8 fast gap", last_gap, FD);
  endtask

  task automatic t_cont(input logic slow, input int gap);
    int ok, start;
    logic [7:0] pc0;
    press(1, 8'h60);
    single_mode = 0; slow_mode = slow;
    pc0 = pc; start = instr_done; writes_running = 0;
    press(8, 8'h00);
    repeat (gap * 5) @(negedge clk);
    check("R6 still running", run_en, 1);
    press(1, 8'hEE); press(2, 8'hEE); press(4, 8'hEE); press(8, 8'hEE);
    check("R8 gap", last_gap, gap);
    repeat (gap) @(negedge clk);
    press(16, 8'h00);
    wait_stop(ok);
    check("R6 stopped", ok, 1);
    check("R6 phase fetch", cpu_phase, 0);
    check("R6 pc advanced", pc, 8'(pc0 + (instr_done - start)));
    check("R6 ran more than one", (instr_done - start) > 1, 1);
    check("R5 no writes running", writes_running, 0);
    check("R5 mem untouched", mem[8'hEE], 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_load();
    t_dep();
    t_exam();
    t_priority();
    t_single();
    t_cont(0, FD);
    t_cont(1, SD);
    check("R8 single-cycle pulses", pulse_run2, 0);
    check("R9 lamps consistent", lamp_bad, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule